// File: doc/BRIEF.md
# Multi-Slot Inter-Processor Mailbox

This block is an array of numbered mailbox slots through which two processor cores pass fixed-length messages. Each slot has a mode/status word holding a one-hot handshake state and an acknowledge-mode bit, plus eight 32-bit data words. A local core reaches every slot through a plain register port with address, write enable, write data, read strobe and read data. The remote side signals through two per-slot input vectors. A doorbell input marks an idle slot as holding a received message. An acknowledge input completes a slot that is transmitting.

A sender moves a slot to the transmit state, picks the acknowledge mode and fills the data words. It then rings the far side, which is outside this block. In automatic mode the remote acknowledge returns the slot straight to idle, and the sender polls the state field until it reads idle. In interrupt mode the acknowledge parks the slot in the acknowledge state and raises a one-cycle pulse for an external interrupt block. Software then writes the idle code to release the slot.

Each slot runs its own four-state machine: IDLE, TX, RX, ACK. These are the named transitions:
- IDLE to RX on the doorbell input (RING), with a pending pulse.
- TX to IDLE on the acknowledge input in automatic mode (AUTO_DONE).
- TX to ACK on the acknowledge input in interrupt mode (IRQ_DONE), with an ack pulse.
- Any state to any state on a bus write of a valid code (SW_SET).

Top module: `mbox_slot_array`

## Requirements
- R1: After reset every slot's mode word reads 0x10 (state IDLE, ack bit 0), every data word reads 0, and both pulse outputs are low.
- R2: Slot n's mode word is at byte address n*0x40. It reads as {24'b0, state[3:0], 3'b0, ack_bit}. The state codes are IDLE=0x1, TX=0x2, RX=0x4 and ACK=0x8. A write sets the state from wdata[7:4] and the ack bit from wdata[0]; all other written bits are dropped.
- R3: A mode write whose wdata[7:4] is not one of the four codes leaves the state unchanged but still updates the ack bit.
- R4: Slot n's data word k (k = 0..7) is at byte address n*0x40 + 0x4 + 4*k. It stores what is written and reads it back, and each slot's words are independent of every other slot's.
- R5: An unmapped address reads 0, and a write to it changes nothing. Unmapped addresses are offsets 0x24 to 0x3C within a slot window, and any address whose two low bits are not zero.
- R6: With ack bit 1, an acknowledge input for a slot in TX moves it to IDLE on the next edge, and no ack pulse is raised.
- R7: With ack bit 0, an acknowledge input for a slot in TX moves it to ACK on the next edge. In that same cycle ack_pulse for the slot is high, and only for that one cycle.
- R8: A doorbell input for a slot in IDLE moves it to RX on the next edge. In that same cycle pend_pulse for the slot is high, and only for that one cycle.
- R9: An acknowledge input for a slot that is not in TX, or a doorbell input for a slot that is not in IDLE, changes no state and raises no pulse.
- R10: If a bus write to a slot's mode word and a remote input for that slot occur in the same cycle, the bus write decides the result and no pulse is raised.
- R11: Read data is registered. It holds the addressed word in the cycle after bus_rd is high and is zero otherwise. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte address (slot in the upper bits, offset in the low six) |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| remote_ack | input | 32 | Per-slot acknowledge from the remote core |
| remote_ring | input | 32 | Per-slot doorbell from the remote core |
| ack_pulse | output | 32 | Per-slot one-cycle acknowledged pulse (interrupt mode) |
| pend_pulse | output | 32 | Per-slot one-cycle message-pending pulse |

## Verification
The assertions check four things on every cycle and for every slot. The state stays one-hot. A pulse appears only together with its matching state transition. No pulse lasts two cycles. An automatic-mode acknowledge in TX always lands in IDLE. Other behaviour can only be shown by the bench's scenarios, because it depends on addresses and data values:
- the field packing of the mode word;
- dropping invalid state codes while keeping the ack bit;
- the independence of data words across slots;
- the silence of unmapped offsets;
- the bus write winning over a simultaneous remote event.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // Fixed per-slot address window of 64 bytes
    localparam int WIN_LG = 6;

    typedef enum logic [3:0] {
        SLOT_IDLE = 4'h1,
        SLOT_TX   = 4'h2,
        SLOT_RX   = 4'h4,
        SLOT_ACK  = 4'h8
    } slot_state_e;

    function automatic logic code_valid(input logic [3:0] c);
        return (c == 4'h1) || (c == 4'h2) || (c == 4'h4) || (c == 4'h8);
    endfunction
endpackage

// File: rtl/mbox_bus_decode.sv
module mbox_bus_decode #(
    parameter int NUM_SLOTS = 32,
    parameter int WORDS     = 8,
    localparam int SW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WIX = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int AW  = SW + mbox_pkg::WIN_LG
) (
    input  logic [AW-1:0]        addr,
    input  logic                 wr,
    output logic [SW-1:0]        slot_idx,
    output logic [WIX-1:0]       word_idx,
    output logic                 is_mode,
    output logic                 is_data,
    output logic                 data_wr,
    output logic [NUM_SLOTS-1:0] mode_wr
);
    logic [3:0] widx;
    logic       aligned;
    logic       slot_ok;

    assign slot_idx = addr[AW-1:mbox_pkg::WIN_LG];
    assign widx     = addr[5:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign slot_ok  = (32'(slot_idx) < NUM_SLOTS);
    assign is_mode  = aligned && slot_ok && (widx == 4'd0);
    assign is_data  = aligned && slot_ok && (widx != 4'd0) && (32'(widx) <= WORDS);
    assign word_idx = WIX'(widx - 4'd1);
    assign data_wr  = wr && is_data;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign mode_wr[g] = wr && is_mode && (slot_idx == SW'(g));
    end
endmodule

// File: rtl/mbox_slot_fsm.sv
module mbox_slot_fsm
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_state,
    input  logic        cfg_auto,
    input  logic        ack_in,
    input  logic        ring_in,
    output slot_state_e state_o,
    output logic        auto_o,
    output logic        ack_pulse_o,
    output logic        pend_pulse_o
);
    slot_state_e st_q, st_d;
    logic        auto_q;
    logic        ack_evt, ring_evt;

    always_comb begin
        st_d     = st_q;
        ack_evt  = 1'b0;
        ring_evt = 1'b0;
        unique case (st_q)
            SLOT_IDLE: begin
                if (ring_in) begin          // RING
                    st_d     = SLOT_RX;
                    ring_evt = 1'b1;
                end
            end
            SLOT_TX: begin
                if (ack_in) begin           // AUTO_DONE / IRQ_DONE
                    st_d    = auto_q ? SLOT_IDLE : SLOT_ACK;
                    ack_evt = !auto_q;
                end
            end
            SLOT_RX, SLOT_ACK: begin
                st_d = st_q;
            end
            default: st_d = SLOT_IDLE;
        endcase
        if (cfg_wr) begin                   // SW_SET wins over remote events
            ack_evt  = 1'b0;
            ring_evt = 1'b0;
            st_d     = code_valid(cfg_state) ? slot_state_e'(cfg_state) : st_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SLOT_IDLE;
            auto_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (cfg_wr) auto_q <= cfg_auto;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_pulse_o  <= 1'b0;
            pend_pulse_o <= 1'b0;
        end else begin
            ack_pulse_o  <= ack_evt;
            pend_pulse_o <= ring_evt;
        end
    end

    assign state_o = st_q;
    assign auto_o  = auto_q;
endmodule

// File: rtl/mbox_data_store.sv
module mbox_data_store #(
    parameter int NUM_SLOTS = 32,
    parameter int WORDS     = 8,
    parameter int DW        = 32,
    localparam int SW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WIX = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [SW-1:0]  slot_idx,
    input  logic [WIX-1:0] word_idx,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rd_word
);
    logic [DW-1:0] mem_q [NUM_SLOTS][WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            mem_q[slot_idx][word_idx] <= wdata;
        end
    end

    assign rd_word = mem_q[slot_idx][word_idx];
endmodule

// File: rtl/mbox_slot_array.sv
module mbox_slot_array
    import mbox_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int WORDS     = 8,
    parameter int DW        = 32,
    localparam int SW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int WIX = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int AW  = SW + WIN_LG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_rd,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_SLOTS-1:0] remote_ack,
    input  logic [NUM_SLOTS-1:0] remote_ring,
    output logic [NUM_SLOTS-1:0] ack_pulse,
    output logic [NUM_SLOTS-1:0] pend_pulse
);
    logic [SW-1:0]              slot_idx;
    logic [WIX-1:0]             word_idx;
    logic                       is_mode, is_data, data_wr;
    logic [NUM_SLOTS-1:0]       mode_wr;
    logic [NUM_SLOTS-1:0][3:0]  slot_st;
    logic [NUM_SLOTS-1:0]       slot_auto;
    logic [DW-1:0]              rd_word, rd_val, rdata_q;

    mbox_bus_decode #(.NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .slot_idx (slot_idx),
        .word_idx (word_idx),
        .is_mode  (is_mode),
        .is_data  (is_data),
        .data_wr  (data_wr),
        .mode_wr  (mode_wr)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_state_e st;
        mbox_slot_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_wr       (mode_wr[g]),
            .cfg_state    (bus_wdata[7:4]),
            .cfg_auto     (bus_wdata[0]),
            .ack_in       (remote_ack[g]),
            .ring_in      (remote_ring[g]),
            .state_o      (st),
            .auto_o       (slot_auto[g]),
            .ack_pulse_o  (ack_pulse[g]),
            .pend_pulse_o (pend_pulse[g])
        );
        assign slot_st[g] = st;
    end

    mbox_data_store #(.NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr),
        .slot_idx (slot_idx),
        .word_idx (word_idx),
        .wdata    (bus_wdata),
        .rd_word  (rd_word)
    );

    always_comb begin
        rd_val = '0;
        if (is_mode) begin
            rd_val[7:4] = slot_st[slot_idx];
            rd_val[0]   = slot_auto[slot_idx];
        end else if (is_data) begin
            rd_val = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/mbox_slot_array_chk.sv
module mbox_slot_array_chk #(
    parameter int NUM_SLOTS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLOTS-1:0]       remote_ack,
    input logic [NUM_SLOTS-1:0]       ack_pulse,
    input logic [NUM_SLOTS-1:0]       pend_pulse,
    input logic [NUM_SLOTS-1:0][3:0]  slot_st,
    input logic [NUM_SLOTS-1:0]       slot_auto,
    input logic [NUM_SLOTS-1:0]       mode_wr
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(slot_st[g]) == 1); // R2
        AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_st[g] == 4'h2 && remote_ack[g] && slot_auto[g] && !mode_wr[g])
            |=> (slot_st[g] == 4'h1)); // R6
        AST_ACK_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            ack_pulse[g] |-> (slot_st[g] == 4'h8 && $past(slot_st[g]) == 4'h2
                              && !$past(slot_auto[g]))); // R7
        AST_ACK_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            ack_pulse[g] |=> !ack_pulse[g]); // R7
        AST_PEND_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            pend_pulse[g] |-> (slot_st[g] == 4'h4 && $past(slot_st[g]) == 4'h1)); // R8
        AST_PEND_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            pend_pulse[g] |=> !pend_pulse[g]); // R8
        AST_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            mode_wr[g] |=> (!ack_pulse[g] && !pend_pulse[g])); // R10
    end
endmodule

bind mbox_slot_array mbox_slot_array_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .remote_ack (remote_ack),
    .ack_pulse  (ack_pulse),
    .pend_pulse (pend_pulse),
    .slot_st    (slot_st),
    .slot_auto  (slot_auto),
    .mode_wr    (mode_wr)
);

// File: tb/test_mbox_slot_array.sv
module test_mbox_slot_array;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] remote_ack = '0;
    logic [NS-1:0] remote_ring = '0;
    logic [NS-1:0] ack_pulse, pend_pulse;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_slot_array i_mbox_slot_array (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .remote_ack(remote_ack), .remote_ring(remote_ring),
        .ack_pulse(ack_pulse), .pend_pulse(pend_pulse)
    );

    function automatic logic [10:0] mode_a(input int s);
        return 11'(s * 64);
    endfunction
    function automatic logic [10:0] data_a(input int s, input int k);
        return 11'(s * 64 + 4 + 4 * k);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares registered read data against the scoreboard queue
    always @(posedge clk) rd_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Pulse a remote input for one cycle, then check the pulse outputs
    task automatic remote(input int s, input bit is_ring, input bit exp_pulse, input string tag);
        @(negedge clk);
        if (is_ring) remote_ring[s] = 1'b1; else remote_ack[s] = 1'b1;
        @(negedge clk);
        remote_ring = '0; remote_ack = '0;
        check({tag, " pulse"}, {31'b0, is_ring ? pend_pulse[s] : ack_pulse[s]}, {31'b0, exp_pulse});
        check({tag, " other pulse"}, {31'b0, is_ring ? ack_pulse[s] : pend_pulse[s]}, 32'h0);
        @(negedge clk);
        check({tag, " pulse drops"}, ack_pulse | pend_pulse, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pulses", ack_pulse | pend_pulse, 32'h0);
        rd(mode_a(0), 32'h10, "R1 mode slot0");
        rd(mode_a(31), 32'h10, "R1 mode slot31");
        rd(data_a(5, 3), 32'h0, "R1 data");
        // R2 mode word packing
        wr(mode_a(2), 32'h21);
        rd(mode_a(2), 32'h21, "R2 tx auto");
        wr(mode_a(2), 32'hFFFF_FF40);
        rd(mode_a(2), 32'h40, "R2 upper bits dropped");
        // R3 invalid code keeps state, updates ack bit
        wr(mode_a(2), 32'h31);
        rd(mode_a(2), 32'h41, "R3 invalid code");
        wr(mode_a(2), 32'h00);
        rd(mode_a(2), 32'h40, "R3 zero code");
        // R4 data words
        for (int k = 0; k < 8; k++) wr(data_a(3, k), 32'hA000_0300 + 32'(k));
        wr(data_a(4, 0), 32'h0000_BEEF);
        wr(data_a(31, 7), 32'h1357_9BDF);
        for (int k = 0; k < 8; k++) rd(data_a(3, k), 32'hA000_0300 + 32'(k), "R4 slot3 word");
        rd(data_a(4, 0), 32'h0000_BEEF, "R4 slot4 word0");
        rd(data_a(31, 7), 32'h1357_9BDF, "R4 slot31 word7");
        rd(data_a(4, 1), 32'h0, "R4 neighbour untouched");
        // R5 unmapped offsets
        wr(11'(3 * 64 + 'h24), 32'hFFFF_FFFF);
        wr(11'(3 * 64 + 'h3C), 32'hFFFF_FFFF);
        wr(11'(3 * 64 + 'h1), 32'hFFFF_FFFF);
        rd(11'(3 * 64 + 'h24), 32'h0, "R5 read 0x24");
        rd(11'(3 * 64 + 'h3C), 32'h0, "R5 read 0x3C");
        rd(11'(3 * 64 + 'h5), 32'h0, "R5 unaligned");
        rd(data_a(3, 7), 32'hA000_0307, "R5 word7 intact");
        rd(data_a(3, 0), 32'hA000_0300, "R5 word0 intact");
        rd(mode_a(3), 32'h10, "R5 mode intact");
        // R6 automatic acknowledge
        wr(mode_a(6), 32'h21);
        remote(6, 1'b0, 1'b0, "R6 auto ack");
        rd(mode_a(6), 32'h11, "R6 back to idle");
        // R7 interrupt acknowledge, then release
        wr(mode_a(7), 32'h20);
        remote(7, 1'b0, 1'b1, "R7 irq ack");
        rd(mode_a(7), 32'h80, "R7 ack state");
        wr(mode_a(7), 32'h10);
        rd(mode_a(7), 32'h10, "R2 release to idle");
        // R8 doorbell
        remote(9, 1'b1, 1'b1, "R8 ring");
        rd(mode_a(9), 32'h40, "R8 rx state");
        // R9 ignored events
        remote(9, 1'b1, 1'b0, "R9 ring in rx");
        remote(9, 1'b0, 1'b0, "R9 ack in rx");
        remote(11, 1'b0, 1'b0, "R9 ack in idle");
        rd(mode_a(9), 32'h40, "R9 rx kept");
        rd(mode_a(11), 32'h10, "R9 idle kept");
        // R10 bus write wins
        wr(mode_a(10), 32'h20);
        @(negedge clk);
        bus_addr = mode_a(10); bus_wdata = 32'h21; bus_wr = 1'b1; remote_ack[10] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; remote_ack = '0;
        check("R10 no ack pulse", ack_pulse, 32'h0);
        rd(mode_a(10), 32'h21, "R10 write result");
        @(negedge clk);
        bus_addr = mode_a(12); bus_wdata = 32'h80; bus_wr = 1'b1; remote_ring[12] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; remote_ring = '0;
        check("R10 no pend pulse", pend_pulse, 32'h0);
        rd(mode_a(12), 32'h80, "R10 ring overridden");
        // R11 read data zero without strobe
        @(negedge clk);
        bus_addr = data_a(3, 2); bus_rd = 1'b0;
        @(negedge clk);
        check("R11 no strobe", bus_rdata, 32'h0);
        rd(data_a(3, 2), 32'hA000_0302, "R11 strobe");
        rd(mode_a(9), 32'h40, "R11 read no side effect");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule